// File: doc/BRIEF.md
# Microcoded Register-ALU Datapath

This block is the data side of a small microprogrammed processor. A microsequencer, which is outside this block, sends one control word per cycle. The fields of that word choose the operands, the ALU operation, the result routing and the register loads. The block holds four kinds of state: a register file, a temporary result register T, a memory address register and a program counter. Register indices come from three fields of the current instruction. Two selectors pick operand registers by field. A third selector picks the second ALU input from a register, the immediate field or one of four small constants.

The block drives the memory address from the address register and the store data from T. The memory write strobe follows the microcontrol bit. The zero flag and the branch condition are combinational. A conditional jump in the same microstep can therefore test the ALU result before it is stored. The ALU operation is either named directly by the control word or taken from the instruction opcode.

Top module: `mux_alu_dp`

## Requirements
- R1: During and after reset, pc_o, addr_o and wdata_o are zero and every register reads zero, and we_o stays low until mw_i is driven high.
- R2: Selectors x_sel_i, y_sel_i and d_sel_i choose a register index field: 0 selects r1_i, 1 selects r2_i, and 2 or 3 selects r3_i. On a rising edge with lr_i high, the write-back value goes into the register indexed by d_sel_i. While lr_i is low, no register changes.
- R3: z_sel_i selects the second ALU input. 0 is the y register, 1 is the immediate sign-extended to the data width, 2 is constant 0, 3 is constant 1, 4 is constant 2, 5 is constant 4, and 6 or 7 give 0.
- R4: alu_op_i encodings, where x is the x register and z is the second input: 0 add, 1 pass x, 2 x minus z, 3 multiply (low half), 4 unsigned divide, 5 and, 6 or, 7 xor, 8 shift left, 9 logical shift right, 10 pass z.
- R5: alu_op_i value 11 takes the operation from opc_i, using the encodings of R4. An opc_i value of 11 or more gives a result of 0.
- R6: A divide by zero gives all ones. A shift uses only the low log2(data width) bits of z.
- R7: r_sel_i picks the register write data: 0 is rdata_i, 1 is T, 2 is the PC and 3 is ads_i.
- R8: On an edge with lmar_i high, the address register loads a value picked by a_sel_i: 0 picks ads_i, 1 the PC, and 2 or 3 picks T. While lmar_i is low it holds. Its value drives addr_o.
- R9: On an edge with lpc_i high, the PC loads a value picked by j_sel_i: 0 picks PC+1, 1 picks ads_i, and 2 or 3 picks the x register. While lpc_i is low it holds.
- R10: T loads the ALU result on an edge with lt_i high and holds otherwise. wdata_o shows T, and we_o follows mw_i in the same cycle.
- R11: zero_o is high in the same cycle whenever the ALU result is zero. cond_o is picked by cc_i: 0 always 1, 1 zero, 2 not zero, 3 result MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| x_sel_i | input | 2 | Field that indexes the x register |
| y_sel_i | input | 2 | Field that indexes the y register |
| z_sel_i | input | 3 | Source of the second ALU input |
| d_sel_i | input | 2 | Field that indexes the destination register |
| a_sel_i | input | 2 | Source for the address register |
| j_sel_i | input | 2 | Source for the next PC |
| r_sel_i | input | 2 | Source of the register write data |
| alu_op_i | input | 4 | ALU operation, or 11 to use the opcode |
| lt_i | input | 1 | Load T |
| lr_i | input | 1 | Write the destination register |
| lmar_i | input | 1 | Load the address register |
| lpc_i | input | 1 | Load the PC |
| mw_i | input | 1 | Memory write strobe |
| r1_i | input | 3 | Instruction register field 1 |
| r2_i | input | 3 | Instruction register field 2 |
| r3_i | input | 3 | Instruction register field 3 |
| imm_i | input | 8 | Instruction immediate |
| ads_i | input | 16 | Instruction address field |
| opc_i | input | 4 | Instruction opcode |
| cc_i | input | 2 | Branch condition select |
| rdata_i | input | 16 | Memory read data |
| addr_o | output | 16 | Memory address (address register) |
| wdata_o | output | 16 | Memory write data (T) |
| we_o | output | 1 | Memory write enable |
| pc_o | output | 16 | Program counter |
| zero_o | output | 1 | ALU result is zero |
| cond_o | output | 1 | Selected branch condition |

## Verification
A wrong operand or constant selection shows on zero_o and cond_o in the same cycle. It shows on wdata_o one edge after T loads. A register write to the wrong place, or a write without lr_i, stays hidden until that register is read back through a pass-x operation into T. That is two edges after the write. Address register and PC faults show on addr_o and pc_o right after the loading edge. A hold fault shows after the first edge on which the load enable is low.

// File: rtl/dp_pkg.sv
package dp_pkg;
  typedef enum logic [1:0] {FLD_R1 = 2'd0, FLD_R2 = 2'd1, FLD_R3 = 2'd2} fld_e;
  typedef enum logic [2:0] {
    Z_Y = 3'd0, Z_IMM = 3'd1, Z_C0 = 3'd2, Z_C1 = 3'd3, Z_C2 = 3'd4, Z_C4 = 3'd5
  } zsel_e;
  typedef enum logic [1:0] {A_ADS = 2'd0, A_PC = 2'd1, A_T = 2'd2} asel_e;
  typedef enum logic [1:0] {J_INC = 2'd0, J_ADS = 2'd1, J_X = 2'd2} jsel_e;
  typedef enum logic [1:0] {W_MEM = 2'd0, W_T = 2'd1, W_PC = 2'd2, W_ADS = 2'd3} wsel_e;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_PASSX = 4'd1, OP_SUB = 4'd2, OP_MUL = 4'd3, OP_DIV = 4'd4,
    OP_AND = 4'd5, OP_OR = 4'd6, OP_XOR = 4'd7, OP_SHL = 4'd8, OP_SHR = 4'd9,
    OP_PASSZ = 4'd10, OP_FROM_OPC = 4'd11
  } aluop_e;
  typedef enum logic [1:0] {CC_ALWAYS = 2'd0, CC_ZERO = 2'd1, CC_NZ = 2'd2, CC_NEG = 2'd3} cc_e;
endpackage

// File: rtl/dp_regfile.sv
module dp_regfile #(
  parameter int DATA_W = 16,
  parameter int NREG   = 8,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  xaddr_i,
  input  logic [IDX_W-1:0]  yaddr_i,
  output logic [DATA_W-1:0] xdata_o,
  output logic [DATA_W-1:0] ydata_o
);
  logic [DATA_W-1:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  assign xdata_o = regs_q[xaddr_i];
  assign ydata_o = regs_q[yaddr_i];

  // R2: written value is visible at the written index one edge later
  p_rf_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> regs_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/dp_alu.sv
module dp_alu import dp_pkg::*; #(
  parameter int DATA_W = 16,
  parameter int OPC_W  = 4,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [3:0]        op_i,
  input  logic [OPC_W-1:0]  opc_i,
  output logic [DATA_W-1:0] res_o
);
  logic [3:0]      eff_op;
  logic [SH_W-1:0] shamt;

  assign eff_op = (op_i == OP_FROM_OPC) ? opc_i[3:0] : op_i;
  assign shamt  = b_i[SH_W-1:0];

  always_comb begin
    unique case (eff_op)
      OP_ADD:   res_o = a_i + b_i;
      OP_PASSX: res_o = a_i;
      OP_SUB:   res_o = a_i - b_i;
      OP_MUL:   res_o = a_i * b_i;
      OP_DIV:   res_o = (b_i == '0) ? '1 : a_i / b_i;
      OP_AND:   res_o = a_i & b_i;
      OP_OR:    res_o = a_i | b_i;
      OP_XOR:   res_o = a_i ^ b_i;
      OP_SHL:   res_o = a_i << shamt;
      OP_SHR:   res_o = a_i >> shamt;
      OP_PASSZ: res_o = b_i;
      default:  res_o = '0;
    endcase
  end
endmodule

// File: rtl/dp_addr_unit.sv
module dp_addr_unit import dp_pkg::*; #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lmar_i,
  input  logic [1:0]        a_sel_i,
  input  logic              lpc_i,
  input  logic [1:0]        j_sel_i,
  input  logic [DATA_W-1:0] ads_i,
  input  logic [DATA_W-1:0] t_i,
  input  logic [DATA_W-1:0] x_i,
  output logic [DATA_W-1:0] pc_o,
  output logic [DATA_W-1:0] mar_o
);
  logic [DATA_W-1:0] pc_q, mar_q, pc_nxt, mar_nxt;

  always_comb begin
    unique case (a_sel_i)
      A_ADS:   mar_nxt = ads_i;
      A_PC:    mar_nxt = pc_q;
      default: mar_nxt = t_i;
    endcase
    unique case (j_sel_i)
      J_INC:   pc_nxt = pc_q + DATA_W'(1);
      J_ADS:   pc_nxt = ads_i;
      default: pc_nxt = x_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      mar_q <= '0;
    end else begin
      if (lpc_i)  pc_q  <= pc_nxt;
      if (lmar_i) mar_q <= mar_nxt;
    end
  end

  assign pc_o  = pc_q;
  assign mar_o = mar_q;

  p_mar_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lmar_i |=> $stable(mar_q));
  p_mar_pc_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lmar_i && a_sel_i == A_PC) |=> mar_q == $past(pc_q));
  p_pc_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lpc_i |=> $stable(pc_q));
  p_pc_inc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lpc_i && j_sel_i == J_INC) |=> pc_q == $past(pc_q) + DATA_W'(1));
endmodule

// File: rtl/mux_alu_dp.sv
module mux_alu_dp import dp_pkg::*; #(
  parameter int DATA_W     = 16,
  parameter int NREG       = 8,
  parameter int IMM_W      = 8,
  parameter int OPC_W      = 4,
  parameter bit IMM_SIGNED = 1'b1,
  localparam int IDX_W     = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        x_sel_i,
  input  logic [1:0]        y_sel_i,
  input  logic [2:0]        z_sel_i,
  input  logic [1:0]        d_sel_i,
  input  logic [1:0]        a_sel_i,
  input  logic [1:0]        j_sel_i,
  input  logic [1:0]        r_sel_i,
  input  logic [3:0]        alu_op_i,
  input  logic              lt_i,
  input  logic              lr_i,
  input  logic              lmar_i,
  input  logic              lpc_i,
  input  logic              mw_i,
  input  logic [IDX_W-1:0]  r1_i,
  input  logic [IDX_W-1:0]  r2_i,
  input  logic [IDX_W-1:0]  r3_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [DATA_W-1:0] ads_i,
  input  logic [OPC_W-1:0]  opc_i,
  input  logic [1:0]        cc_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              we_o,
  output logic [DATA_W-1:0] pc_o,
  output logic              zero_o,
  output logic              cond_o
);
  logic [IDX_W-1:0]  x_idx, y_idx, d_idx;
  logic [DATA_W-1:0] x_val, y_val, z_val, imm_ext, alu_res, wb_val, t_q, pc_val;

  function automatic logic [IDX_W-1:0] pick_fld(input logic [1:0] s,
      input logic [IDX_W-1:0] f1, input logic [IDX_W-1:0] f2, input logic [IDX_W-1:0] f3);
    case (s)
      FLD_R1:  return f1;
      FLD_R2:  return f2;
      default: return f3;
    endcase
  endfunction

  assign x_idx = pick_fld(x_sel_i, r1_i, r2_i, r3_i);
  assign y_idx = pick_fld(y_sel_i, r1_i, r2_i, r3_i);
  assign d_idx = pick_fld(d_sel_i, r1_i, r2_i, r3_i);

  generate
    if (IMM_SIGNED) begin : g_imm_sx
      assign imm_ext = {{(DATA_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
    end else begin : g_imm_zx
      assign imm_ext = {{(DATA_W-IMM_W){1'b0}}, imm_i};
    end
  endgenerate

  always_comb begin
    unique case (z_sel_i)
      Z_Y:     z_val = y_val;
      Z_IMM:   z_val = imm_ext;
      Z_C1:    z_val = DATA_W'(1);
      Z_C2:    z_val = DATA_W'(2);
      Z_C4:    z_val = DATA_W'(4);
      default: z_val = '0;
    endcase
    unique case (r_sel_i)
      W_MEM:   wb_val = rdata_i;
      W_T:     wb_val = t_q;
      W_PC:    wb_val = pc_val;
      default: wb_val = ads_i;
    endcase
  end

  dp_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
    .clk_i, .rst_ni, .we_i(lr_i), .waddr_i(d_idx), .wdata_i(wb_val),
    .xaddr_i(x_idx), .yaddr_i(y_idx), .xdata_o(x_val), .ydata_o(y_val)
  );

  dp_alu #(.DATA_W(DATA_W), .OPC_W(OPC_W)) u_alu (
    .a_i(x_val), .b_i(z_val), .op_i(alu_op_i), .opc_i, .res_o(alu_res)
  );

  dp_addr_unit #(.DATA_W(DATA_W)) u_addr (
    .clk_i, .rst_ni, .lmar_i, .a_sel_i, .lpc_i, .j_sel_i, .ads_i,
    .t_i(t_q), .x_i(x_val), .pc_o(pc_val), .mar_o(addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   t_q <= '0;
    else if (lt_i) t_q <= alu_res;
  end

  assign zero_o = (alu_res == '0);
  always_comb begin
    unique case (cc_i)
      CC_ALWAYS: cond_o = 1'b1;
      CC_ZERO:   cond_o = zero_o;
      CC_NZ:     cond_o = !zero_o;
      default:   cond_o = alu_res[DATA_W-1];
    endcase
  end

  assign wdata_o = t_q;
  assign we_o    = mw_i;
  assign pc_o    = pc_val;

  p_t_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lt_i |=> $stable(t_q));
  p_zero_t_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lt_i && zero_o) |=> t_q == '0);
endmodule

// File: tb/mux_alu_dp_test.sv
`timescale 1ns/1ps
module mux_alu_dp_test;
  localparam int DW = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] x_sel, y_sel, d_sel, a_sel, j_sel, r_sel, cc;
  logic [2:0] z_sel;
  logic [3:0] alu_op, opc;
  logic lt, lr, lmar, lpc, mw;
  logic [2:0] r1, r2, r3;
  logic [7:0] imm;
  logic [DW-1:0] ads, rdata, addr, wdata, pc;
  logic we, zero, cond;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  mux_alu_dp uut (
    .clk_i(clk), .rst_ni(rst_n), .x_sel_i(x_sel), .y_sel_i(y_sel), .z_sel_i(z_sel),
    .d_sel_i(d_sel), .a_sel_i(a_sel), .j_sel_i(j_sel), .r_sel_i(r_sel), .alu_op_i(alu_op),
    .lt_i(lt), .lr_i(lr), .lmar_i(lmar), .lpc_i(lpc), .mw_i(mw),
    .r1_i(r1), .r2_i(r2), .r3_i(r3), .imm_i(imm), .ads_i(ads), .opc_i(opc), .cc_i(cc),
    .rdata_i(rdata), .addr_o(addr), .wdata_o(wdata), .we_o(we), .pc_o(pc),
    .zero_o(zero), .cond_o(cond)
  );

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle();
    x_sel = 0; y_sel = 0; z_sel = 0; d_sel = 0; a_sel = 0; j_sel = 0; r_sel = 0;
    alu_op = 0; opc = 0; cc = 0; lt = 0; lr = 0; lmar = 0; lpc = 0; mw = 0;
    r1 = 0; r2 = 0; r3 = 0; imm = 0; ads = 0; rdata = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input int idx, input logic [DW-1:0] v);
    idle(); r1 = 3'(idx); d_sel = 0; r_sel = 3; ads = v; lr = 1; tick(); idle();
  endtask

  task automatic rd(input int idx, output logic [DW-1:0] v);
    idle(); r1 = 3'(idx); x_sel = 0; alu_op = 1; lt = 1; tick(); v = wdata; idle();
  endtask

  // x from r1 field, y from r2 field
  task automatic run(input int xi, input int yi, input logic [2:0] zs, input logic [7:0] im,
                     input logic [3:0] op, input logic [3:0] oc, output logic [DW-1:0] v);
    idle(); r1 = 3'(xi); r2 = 3'(yi); x_sel = 0; y_sel = 1; z_sel = zs; imm = im;
    alu_op = op; opc = oc; lt = 1; tick(); v = wdata; idle();
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    chk("R1 pc", pc, 0); chk("R1 addr", addr, 0); chk("R1 wdata", wdata, 0);
    chk("R1 we", DW'(we), 0);
    rd(5, v); chk("R1 reg5", v, 0);
  endtask

  task automatic t_regs();
    logic [DW-1:0] v;
    wr(1, 100); wr(2, 7); wr(4, 17);
    idle(); r3 = 6; d_sel = 2; r_sel = 3; ads = 16'h8000; lr = 1; tick(); idle();
    rd(6, v); chk("R2 d=r3 write", v, 16'h8000);
    idle(); r2 = 1; x_sel = 1; alu_op = 1; lt = 1; tick(); chk("R2 x=r2", wdata, 100);
    idle(); r3 = 4; x_sel = 2; alu_op = 1; lt = 1; tick(); chk("R2 x=r3", wdata, 17);
    idle(); r1 = 1; r3 = 2; y_sel = 2; alu_op = 0; lt = 1; tick(); chk("R2 y=r3", wdata, 107);
    idle(); r1 = 1; ads = 16'h5555; r_sel = 3; lr = 0; tick(); idle();
    rd(1, v); chk("R2 no lr", v, 100);
  endtask

  task automatic t_zsel();
    logic [DW-1:0] v;
    run(3, 4, 0, 0, 0, 0, v); chk("R3 z=y", v, 17);
    run(3, 4, 1, 8'h85, 0, 0, v); chk("R3 z=imm", v, 16'hFF85);
    run(1, 4, 2, 0, 0, 0, v); chk("R3 z=0", v, 100);
    run(3, 4, 3, 0, 0, 0, v); chk("R3 z=1", v, 1);
    run(3, 4, 4, 0, 0, 0, v); chk("R3 z=2", v, 2);
    run(3, 4, 5, 0, 0, 0, v); chk("R3 z=4", v, 4);
  endtask

  task automatic t_ops();
    logic [DW-1:0] exp [11] = '{107, 100, 93, 700, 14, 4, 103, 99, 12800, 0, 7};
    logic [DW-1:0] v;
    for (int k = 0; k < 11; k++) begin
      run(1, 2, 0, 0, 4'(k), 0, v); chk($sformatf("R4 op%0d", k), v, exp[k]);
    end
  endtask

  task automatic t_opcode();
    logic [DW-1:0] v;
    run(1, 2, 0, 0, 11, 2, v); chk("R5 opc sub", v, 93);
    run(1, 2, 0, 0, 11, 7, v); chk("R5 opc xor", v, 99);
    run(1, 2, 0, 0, 11, 13, v); chk("R5 opc undefined", v, 0);
  endtask

  task automatic t_corner();
    logic [DW-1:0] v;
    run(1, 3, 0, 0, 4, 0, v); chk("R6 div0", v, 16'hFFFF);
    run(1, 4, 0, 0, 8, 0, v); chk("R6 shl 17", v, 200);
    run(6, 0, 1, 8'h1F, 9, 0, v); chk("R6 shr 31", v, 1);
  endtask

  task automatic t_wb();
    logic [DW-1:0] v;
    idle(); r1 = 1; alu_op = 1; lt = 1; tick();
    idle(); r1 = 5; r_sel = 1; lr = 1; tick(); idle(); rd(5, v); chk("R7 from T", v, 100);
    idle(); r1 = 5; r_sel = 0; rdata = 16'hBEEF; lr = 1; tick(); idle();
    rd(5, v); chk("R7 from mem", v, 16'hBEEF);
    idle(); j_sel = 1; ads = 16'h0040; lpc = 1; tick();
    idle(); r1 = 5; r_sel = 2; lr = 1; tick(); idle(); rd(5, v); chk("R7 from pc", v, 16'h0040);
  endtask

  task automatic t_mar();
    idle(); a_sel = 0; ads = 16'h0123; lmar = 1; tick(); chk("R8 mar=ads", addr, 16'h0123);
    idle(); a_sel = 1; lmar = 1; tick(); chk("R8 mar=pc", addr, 16'h0040);
    idle(); r1 = 2; alu_op = 1; lt = 1; tick();
    idle(); a_sel = 2; lmar = 1; tick(); chk("R8 mar=t", addr, 7);
    idle(); a_sel = 0; ads = 16'h0999; lmar = 0; tick(); chk("R8 hold", addr, 7);
  endtask

  task automatic t_pc();
    idle(); j_sel = 1; ads = 16'h0200; lpc = 1; tick(); chk("R9 pc=ads", pc, 16'h0200);
    idle(); j_sel = 0; lpc = 1; tick(); chk("R9 pc+1", pc, 16'h0201);
    idle(); r1 = 1; x_sel = 0; j_sel = 2; lpc = 1; tick(); chk("R9 pc=x", pc, 100);
    idle(); j_sel = 1; ads = 16'h0777; lpc = 0; tick(); chk("R9 hold", pc, 100);
  endtask

  task automatic t_t();
    idle(); r1 = 2; alu_op = 1; lt = 1; tick();
    idle(); r1 = 1; alu_op = 1; lt = 0; tick(); chk("R10 T hold", wdata, 7);
    idle(); mw = 1; #1; chk("R10 we high", DW'(we), 1); chk("R10 wdata", wdata, 7);
    mw = 0; #1; chk("R10 we low", DW'(we), 0);
    idle();
  endtask

  task automatic t_flags();
    idle(); r1 = 1; r2 = 1; y_sel = 1; z_sel = 0; alu_op = 2; #1;
    chk("R11 zero", DW'(zero), 1);
    cc = 1; #1; chk("R11 cc zero", DW'(cond), 1);
    cc = 2; #1; chk("R11 cc nz", DW'(cond), 0);
    cc = 0; #1; chk("R11 cc always", DW'(cond), 1);
    z_sel = 3; cc = 2; #1; chk("R11 nonzero", DW'(zero), 0); chk("R11 cc nz set", DW'(cond), 1);
    idle(); r1 = 6; alu_op = 1; cc = 3; #1; chk("R11 neg", DW'(cond), 1);
    r1 = 1; #1; chk("R11 not neg", DW'(cond), 0);
    idle();
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle();
    #9 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_zsel();
    t_ops();
    t_opcode();
    t_corner();
    t_wb();
    t_mar();
    t_pc();
    t_t();
    t_flags();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule